// File: doc/BRIEF.md
# Sequential Arithmetic Right Shift Unit

This block runs a sign-preserving right shift on a 32-bit data register at one of three operand sizes: 8, 16 or 32 bits. It takes a decoded 16-bit shift instruction word, the value of the destination register and the value of the register that may supply the count. It returns the new register value and five condition flags (extend, negative, zero, overflow, carry). A one-cycle done strobe marks the result. The strobe does not come at once. It arrives after a latency that grows with the operand size and with the number of bit positions moved, so the surrounding sequencer sees the same timing as a machine that shifts one bit every two clocks.

A second mode serves the in-memory form of the operation. In that mode the unit takes a 16-bit word, moves it exactly one place to the right and copies bit 15 back into itself. Fetching and storing the word, computing addresses and holding the register file all stay with the caller. The caller raises `start_i` for one cycle while the unit is idle, with every operand valid in that cycle. It then waits for `done_o`. The result and flags stay unchanged until the next accepted request.

Top module: `asr_seq_unit`

## Requirements
- R1: Instruction decode. Bits 7:6 select the size (00 = 8-bit, 01 = 16-bit, 10 = 32-bit). Bit 5 = 1 takes the count from `count_reg_i`. Bit 5 = 0 takes the count from bits 11:9, where a field value of 0 means a shift of 8 and values 1 to 7 are used as they are.
- R2: A count taken from `count_reg_i` uses that value modulo 64. For example, 105 gives an effective shift of 41.
- R3: The shifted lane fills its vacated high bits with the lane's sign bit. For 8-bit and 16-bit sizes, bits of `dest_i` above the lane appear unchanged in `result_o`.
- R4: When the effective count is at least the lane width, the lane becomes all ones for a negative operand, with C and X set. For a non-negative operand the lane becomes all zeros, with C and X cleared.
- R5: For a count from 1 up to the lane width, C and X both equal the last bit shifted out of the lane.
- R6: With an effective count of 0, the lane is unchanged, C is 0 and X equals `x_flag_i`.
- R7: N is the most significant bit of the result lane. Z is 1 exactly when every bit of the lane is 0. V is always 0.
- R8: `done_o` rises T clock cycles after the cycle in which `start_i` is accepted, counting that cycle. T = 6 + 2n for 8-bit and 16-bit sizes and T = 8 + 2n for 32-bit size, where n is the effective count.
- R9: With `mem_mode_i` = 1 the operand is `mem_word_i`. It is shifted right by exactly one place with bit 15 kept. C and X take the old bit 0, bits 31:16 of `result_o` are 0, and the 16-bit timing of R8 applies (T = 8).
- R10: A `start_i` raised while an operation is in progress is ignored. `result_o` and `flags_o` hold their values until the next accepted start. `done_o` is high for exactly one cycle per accepted start.
- R11: While `rst_n` is low, `done_o`, `result_o` and `flags_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request pulse, accepted only when idle |
| mem_mode_i | input | 1 | 1 = one-place 16-bit memory-word form |
| opcode_i | input | 16 | Decoded shift instruction word |
| dest_i | input | 32 | Destination register value |
| count_reg_i | input | 32 | Count register value |
| mem_word_i | input | 16 | Operand for the memory-word form |
| x_flag_i | input | 1 | Current extend flag |
| result_o | output | 32 | New register or memory-word value |
| flags_o | output | 5 | {X, N, Z, V, C} |
| done_o | output | 1 | One-cycle completion strobe |

## Verification
The assertions rely on three conditions:
- Reset is asserted from time zero, so the run state starts out idle.
- The size field never holds 11.
- `start_i` is a registered single-bit signal.

Given these, the assertions check that the strobe is a single pulse that only ever ends a run, that the outputs stay frozen during a run, and that the flag combinations stay legal.

The stimulus uses only the three defined size codes. It waits for each strobe before it issues the next request. The one exception is a deliberate extra start raised in the middle of a run, which exercises the ignore rule.

// File: rtl/asr_pkg.sv
package asr_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10
  } opsize_e;

  typedef struct packed {
    logic x;
    logic n;
    logic z;
    logic v;
    logic c;
  } ccr_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;

endpackage

// File: rtl/asr_decode.sv
module asr_decode
  import asr_pkg::*;
#(
  parameter int CNT_W  = 6,
  parameter int IMM_W  = 3
) (
  input  logic             mem_mode_i,
  input  logic [15:0]      opcode_i,
  input  logic [CNT_W-1:0] count_low_i,
  output opsize_e          size_o,
  output logic [CNT_W-1:0] shamt_o
);

  localparam int IMM_ZERO_MEANS = 1 << IMM_W;

  logic [IMM_W-1:0] imm_field;
  logic             use_reg;

  assign imm_field = opcode_i[9 +: IMM_W];
  assign use_reg   = opcode_i[5];

  always_comb begin
    size_o  = SZ_LONG;
    shamt_o = '0;
    if (mem_mode_i) begin
      size_o  = SZ_WORD;
      shamt_o = CNT_W'(1);
    end else begin
      case (opcode_i[7:6])
        2'b00:   size_o = SZ_BYTE;
        2'b01:   size_o = SZ_WORD;
        default: size_o = SZ_LONG;
      endcase
      if (use_reg) begin
        shamt_o = count_low_i;
      end else if (imm_field == '0) begin
        shamt_o = CNT_W'(IMM_ZERO_MEANS);
      end else begin
        shamt_o = CNT_W'(imm_field);
      end
    end
  end

  logic unused_opcode_bits;
  assign unused_opcode_bits = ^{opcode_i[15:12], opcode_i[8], opcode_i[4:0]};

endmodule

// File: rtl/asr_shift_core.sv
module asr_shift_core
  import asr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 6
) (
  input  opsize_e           size_i,
  input  logic [CNT_W-1:0]  shamt_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic              x_prev_i,
  output logic [DATA_W-1:0] result_o,
  output ccr_t              flags_o
);

  localparam int EXT_W = DATA_W + 1;

  logic                    sign;
  logic [DATA_W-1:0]       sext;
  logic signed [EXT_W-1:0] ext;
  logic signed [EXT_W-1:0] shifted;
  logic [DATA_W-1:0]       lane;
  logic                    last_out;
  logic                    moved;

  // sign-extend the active lane so one arithmetic shifter serves all sizes
  always_comb begin
    case (size_i)
      SZ_BYTE: begin
        sign = operand_i[7];
        sext = {{(DATA_W-8){operand_i[7]}}, operand_i[7:0]};
      end
      SZ_WORD: begin
        sign = operand_i[15];
        sext = {{(DATA_W-16){operand_i[15]}}, operand_i[15:0]};
      end
      default: begin
        sign = operand_i[DATA_W-1];
        sext = operand_i;
      end
    endcase
  end

  // a guard bit below the lane catches the last bit shifted out
  assign ext      = {sext, 1'b0};
  assign shifted  = ext >>> shamt_i;
  assign lane     = shifted[EXT_W-1:1];
  assign last_out = shifted[0];
  assign moved    = (shamt_i != '0);

  always_comb begin
    flags_o.v = 1'b0;
    flags_o.c = moved & last_out;
    flags_o.x = moved ? last_out : x_prev_i;
    case (size_i)
      SZ_BYTE: begin
        result_o  = {operand_i[DATA_W-1:8], lane[7:0]};
        flags_o.n = lane[7];
        flags_o.z = (lane[7:0] == 8'h00);
      end
      SZ_WORD: begin
        result_o  = {operand_i[DATA_W-1:16], lane[15:0]};
        flags_o.n = lane[15];
        flags_o.z = (lane[15:0] == 16'h0000);
      end
      default: begin
        result_o  = lane;
        flags_o.n = lane[DATA_W-1];
        flags_o.z = (lane == '0);
      end
    endcase
  end

  logic unused_sign;
  assign unused_sign = sign;

endmodule

// File: rtl/asr_cycle_timer.sv
module asr_cycle_timer #(
  parameter int TIME_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [TIME_W-1:0] load_val_i,
  input  logic              en_i,
  output logic              last_o
);

  logic [TIME_W-1:0] cnt_q;
  logic [TIME_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (en_i && (cnt_q != '0)) begin
      cnt_d = cnt_q - TIME_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i || en_i) begin
      cnt_q <= cnt_d;
    end
  end

  assign last_o = en_i && (cnt_q == TIME_W'(1));

endmodule

// File: rtl/asr_seq_unit.sv
module asr_seq_unit
  import asr_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int CNT_W      = 6,
  parameter int BASE_SHORT = 6,
  parameter int BASE_LONG  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              mem_mode_i,
  input  logic [15:0]       opcode_i,
  input  logic [DATA_W-1:0] dest_i,
  input  logic [DATA_W-1:0] count_reg_i,
  input  logic [15:0]       mem_word_i,
  input  logic              x_flag_i,
  output logic [DATA_W-1:0] result_o,
  output logic [4:0]        flags_o,
  output logic              done_o
);

  localparam int TIME_W = CNT_W + 3;

  run_state_e        state_q, state_d;
  logic [DATA_W-1:0] res_q, res_d;
  ccr_t              flg_q, flg_d;
  logic              done_q, done_d;
  logic              run_active;
  logic              accept;
  logic              last_cycle;

  opsize_e           size;
  logic [CNT_W-1:0]  shamt;
  logic [DATA_W-1:0] operand;
  logic [DATA_W-1:0] core_res;
  ccr_t              core_flg;
  logic [TIME_W-1:0] total_cycles;
  logic [TIME_W-1:0] timer_load;

  assign run_active = (state_q == ST_RUN);
  assign accept     = (state_q == ST_IDLE) && start_i;

  asr_decode #(.CNT_W(CNT_W)) decode_i (
    .mem_mode_i  (mem_mode_i),
    .opcode_i    (opcode_i),
    .count_low_i (count_reg_i[CNT_W-1:0]),
    .size_o      (size),
    .shamt_o     (shamt)
  );

  assign operand = mem_mode_i ? {{(DATA_W-16){1'b0}}, mem_word_i} : dest_i;

  asr_shift_core #(.DATA_W(DATA_W), .CNT_W(CNT_W)) core_i (
    .size_i    (size),
    .shamt_i   (shamt),
    .operand_i (operand),
    .x_prev_i  (x_flag_i),
    .result_o  (core_res),
    .flags_o   (core_flg)
  );

  // two cycles per bit moved on top of a size-dependent base
  assign total_cycles = ((size == SZ_LONG) ? TIME_W'(BASE_LONG) : TIME_W'(BASE_SHORT))
                      + TIME_W'({shamt, 1'b0});
  assign timer_load   = total_cycles - TIME_W'(1);

  asr_cycle_timer #(.TIME_W(TIME_W)) timer_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (accept),
    .load_val_i (timer_load),
    .en_i       (run_active),
    .last_o     (last_cycle)
  );

  always_comb begin
    state_d = state_q;
    res_d   = res_q;
    flg_d   = flg_q;
    done_d  = 1'b0;
    if (accept) begin
      state_d = ST_RUN;
      res_d   = core_res;
      flg_d   = core_flg;
    end else if (run_active && last_cycle) begin
      state_d = ST_IDLE;
      done_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      flg_q <= '0;
    end else if (accept) begin
      res_q <= res_d;
      flg_q <= flg_d;
    end
  end

  assign result_o = res_q;
  assign flags_o  = flg_q;
  assign done_o   = done_q;

endmodule

// File: rtl/asr_seq_unit_chk.sv
module asr_seq_unit_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run_active,
  input logic [DATA_W-1:0] result_o,
  input logic [4:0]        flags_o,
  input logic              done_o
);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R10
  done_ends_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(run_active) && !run_active);

  // R10
  hold_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_active && $past(run_active)) |-> ($stable(result_o) && $stable(flags_o)));

  // R5
  carry_extend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && flags_o[0]) |-> flags_o[4]);

  // R7
  neg_zero_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !(flags_o[3] && flags_o[2]));

  // R7
  ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !flags_o[1]);

endmodule

bind asr_seq_unit asr_seq_unit_chk #(.DATA_W(DATA_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .run_active (run_active),
  .result_o   (result_o),
  .flags_o    (flags_o),
  .done_o     (done_o)
);

// File: tb/asr_seq_unit_tb_top.sv
module asr_seq_unit_tb_top;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [31:0] res;
    logic [4:0]  flg;
    int          done_cyc;
    string       req;
  } item_t;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic        mem_mode_i;
  logic [15:0] opcode_i;
  logic [31:0] dest_i;
  logic [31:0] count_reg_i;
  logic [15:0] mem_word_i;
  logic        x_flag_i;
  logic [31:0] result_o;
  logic [4:0]  flags_o;
  logic        done_o;

  int    checks = 0;
  int    errors = 0;
  int    cyc    = 0;
  bit    finished = 0;
  item_t sb_q[$];

  asr_seq_unit dut_i (
    .clk (clk), .rst_n (rst_n), .start_i (start_i), .mem_mode_i (mem_mode_i),
    .opcode_i (opcode_i), .dest_i (dest_i), .count_reg_i (count_reg_i),
    .mem_word_i (mem_word_i), .x_flag_i (x_flag_i),
    .result_o (result_o), .flags_o (flags_o), .done_o (done_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  function automatic logic [15:0] mk_op(input logic [2:0] cnt, input logic [1:0] sz, input bit use_reg);
    return {4'he, cnt, 1'b0, sz, use_reg, 2'b00, 3'b001};
  endfunction

  // bit-serial reference model written from the requirements
  function automatic item_t model(input bit mem, input logic [15:0] op, input logic [31:0] dest,
                                  input logic [31:0] creg, input logic [15:0] mw, input bit xin);
    item_t it;
    int w, n;
    logic [31:0] dst, msk, v;
    bit sgn, c, x;
    if (mem) begin
      w = 16; n = 1; dst = {16'h0, mw};
    end else begin
      case (op[7:6])
        2'b00:   w = 8;
        2'b01:   w = 16;
        default: w = 32;
      endcase
      if (op[5]) n = int'(creg % 64);
      else       n = (op[11:9] == 3'd0) ? 8 : int'(op[11:9]);
      dst = dest;
    end
    msk = (w == 32) ? 32'hffff_ffff : ((32'h1 << w) - 32'h1);
    v   = dst & msk;
    sgn = v[w-1];
    c   = 1'b0;
    x   = xin;
    for (int i = 0; i < n; i++) begin
      c = v[0];
      v = (v >> 1) | (sgn ? (32'h1 << (w - 1)) : 32'h0);
      x = c;
    end
    it.res      = (dst & ~msk) | v;
    it.flg      = {x, v[w-1], (v == 32'h0), 1'b0, c};
    it.done_cyc = ((w == 32) ? 8 : 6) + 2 * n;
    it.req      = "";
    return it;
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (sb_q.size() == 0) begin
        check("R10 unexpected done", 32'h1, 32'h0);
      end else begin
        item_t e;
        e = sb_q.pop_front();
        check({e.req, " result"}, result_o, e.res);
        check({e.req, " flags"}, {27'h0, flags_o}, {27'h0, e.flg});
        check("R8 done cycle", cyc, e.done_cyc);
      end
    end
  end

  task automatic run_op(input string req, input bit mem, input logic [15:0] op,
                        input logic [31:0] dest, input logic [31:0] creg,
                        input logic [15:0] mw, input bit xin, input bit poke_mid);
    item_t e;
    @(negedge clk);
    e = model(mem, op, dest, creg, mw, xin);
    e.req = req;
    e.done_cyc = cyc + e.done_cyc;
    sb_q.push_back(e);
    mem_mode_i = mem; opcode_i = op; dest_i = dest; count_reg_i = creg;
    mem_word_i = mw; x_flag_i = xin; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (poke_mid) begin
      // R10: a start while busy carries different operands and must be ignored
      @(negedge clk);
      mem_mode_i = 1'b0; opcode_i = mk_op(3'd1, 2'b10, 1'b0);
      dest_i = 32'h1234_5678; x_flag_i = ~xin; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (sb_q.size() != 0) @(negedge clk);
    @(negedge clk);
    check("R10 done single cycle", {31'h0, done_o}, 32'h0);
    check("R10 result held", result_o, e.res);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check("watchdog expired", 32'h1, 32'h0);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; mem_mode_i = 1'b0; opcode_i = '0;
    dest_i = '0; count_reg_i = '0; mem_word_i = '0; x_flag_i = 1'b0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 done", {31'h0, done_o}, 32'h0);
    check("R11 result", result_o, 32'h0);
    check("R11 flags", {27'h0, flags_o}, 32'h0);
    rst_n = 1'b1;

    // R1 R3 R5: 8-bit, count register 2
    run_op("R3 byte reg2", 0, mk_op(3'd2, 2'b00, 1), 32'hce3dd567, 32'd2, 16'h0, 0, 0);
    // R2 R4: 105 -> 41, positive byte saturates to zero
    run_op("R2 byte reg105", 0, mk_op(3'd2, 2'b00, 1), 32'hce3dd567, 32'd105, 16'h0, 1, 0);
    // R6: zero count keeps prior X = 1
    run_op("R6 word zero xset", 0, mk_op(3'd2, 2'b01, 1), 32'hce3dd567, 32'd0, 16'h0, 1, 0);
    // R6: zero count keeps prior X = 0
    run_op("R6 word zero xclr", 0, mk_op(3'd2, 2'b00, 1), 32'h0000_0080, 32'd64, 16'h0, 0, 0);
    // R3 R5: 16-bit, count 11, upper half preserved
    run_op("R3 word reg11", 0, mk_op(3'd2, 2'b01, 1), 32'hce3dd567, 32'd11, 16'h0, 0, 0);
    // R4: 32-bit negative, count 32
    run_op("R4 long reg32", 0, mk_op(3'd2, 2'b10, 1), 32'hce3dd567, 32'h20, 16'h0, 0, 0);
    // R4: 32-bit positive, count 63
    run_op("R4 long pos63", 0, mk_op(3'd2, 2'b10, 1), 32'h7fff_ffff, 32'd63, 16'h0, 1, 0);
    // R1: immediate field 0 means 8
    run_op("R1 long imm0", 0, mk_op(3'd0, 2'b10, 0), 32'hce3dd567, 32'h20, 16'h0, 0, 0);
    // R1: immediate 3, register value ignored
    run_op("R1 word imm3", 0, mk_op(3'd3, 2'b01, 0), 32'hab12_8004, 32'd50, 16'h0, 0, 0);
    // R7: zero result at byte lane, N clear
    run_op("R7 byte imm1 zero", 0, mk_op(3'd1, 2'b00, 0), 32'hffff_ff01, 32'd0, 16'h0, 0, 0);
    // R9: memory word forms
    run_op("R9 mem 8ccc", 1, 16'h0, 32'hffff_ffff, 32'd40, 16'h8ccc, 0, 0);
    run_op("R9 mem 8578", 1, 16'h0, 32'h0, 32'd0, 16'h8578, 1, 0);
    run_op("R9 mem 0001", 1, 16'h0, 32'h0, 32'd0, 16'h0001, 0, 0);
    // R10: start raised mid-run is ignored
    run_op("R10 busy poke", 0, mk_op(3'd2, 2'b01, 1), 32'h5555_a5a5, 32'd4, 16'h0, 0, 1);
    // R5 R8: 32-bit, count 1, last bit out is 1
    run_op("R5 long reg1", 0, mk_op(3'd2, 2'b10, 1), 32'h0000_0003, 32'd1, 16'h0, 0, 0);

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule